// File: doc/BRIEF.md
# DRAM Bank Access Latency Calculator

This block works out, for one DRAM request at a time, how many cycles the access will take given what each bank is currently doing. Every bank keeps a small record: whether a row is open and which one, the cycle at which the bank stops being busy, and the earliest cycle at which it may be activated again. A request names a bank, a row and its arrival cycle. The block compares it with that bank's record and returns the total access latency and the part of it during which the bank itself is occupied. It then rewrites the bank's record so that the next request to the same bank sees the effect of this one.

Three page policies can be selected at run time. Both open policies leave the row open after an access, so a later request to the same row is a row hit. The adaptive policy also takes a per-request hint from the scheduler: the queue holds a conflicting request for that bank and no further hit. When the hint is set, the row is closed after the access. The close policy precharges after every access, so every request starts from a closed bank. All timing values are run-time inputs counted in cycles. The result appears one cycle after the request, with a single-cycle valid pulse.

Top module: `dram_bank_latency`

## Requirements
- R1: `res_vld` is high for exactly one cycle, in the cycle after each cycle in which `req_vld` is high, and is low at all other times.
- R2: If the bank's free cycle is later than `req_now`, the difference is added to the access latency. Otherwise nothing is added.
- R3: Under the open (`cfg_policy`=0) or adaptive (`cfg_policy`=1) policy, a request to the bank's open row is a hit: `res_hit`=1, the bank latency equals `cfg_tcl`, and the access latency is the R2 wait plus `cfg_tcl`.
- R4: On a miss, the precharge delay is `cfg_trp` when the bank has an open row and zero when it has none.
- R5: On a miss, a candidate activate cycle is formed as `req_now` + R2 wait + precharge delay. If this falls before the bank's earliest activate cycle, the shortfall is added to the access latency.
- R6: On a miss, precharge delay + `cfg_trcd` + `cfg_tcl` is added to the access latency, and the bank latency equals exactly that sum.
- R7: After a request under the open policy, the requested row is open, the bank's free cycle becomes `req_now` + access latency, and on a miss the earliest activate cycle becomes the activate cycle of that miss plus `cfg_trc`. A hit leaves the earliest activate cycle unchanged.
- R8: After a request under the adaptive policy with `req_close_hint`=1, the bank has no open row and its free cycle becomes `req_now` + access latency + `cfg_trp`. Without the hint, the update follows R7.
- R9: Under the close policy (`cfg_policy`=2, and also 3), a request never hits and never pays a precharge delay. The bank has no open row afterwards and its free cycle becomes `req_now` + access latency + `cfg_trp`.
- R10: Under the open policy, `req_close_hint` has no effect.
- R11: After reset, every bank has no open row, a free cycle of 0 and an earliest activate cycle of 0, and `res_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy | input | 2 | Page policy: 0 open, 1 adaptive, 2 or 3 close |
| cfg_trp | input | TP_W | Precharge time in cycles |
| cfg_trcd | input | TP_W | Activate-to-column time in cycles |
| cfg_tcl | input | TP_W | Column access time in cycles |
| cfg_trc | input | TP_W | Minimum spacing between activates to one bank |
| req_vld | input | 1 | Request present this cycle |
| req_bank | input | clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_now | input | TIME_W | Arrival cycle of the request |
| req_close_hint | input | 1 | Adaptive policy: close the row after this access |
| res_vld | output | 1 | Result valid pulse |
| res_acc_lat | output | TIME_W | Total access latency |
| res_bank_lat | output | TIME_W | Bank-busy part of the latency |
| res_hit | output | 1 | Request was a row hit |

## Verification
The assertions assume that the timing inputs stay stable while a request is in flight and that arrival cycles never run backwards. They also assume that cycle values stay far below the point where `TIME_W` bits would wrap. The stimulus sets the configuration only between phases while no request is pending. It advances the arrival cycle by a small non-negative random step for each request and keeps the total run within a few thousand cycles. Banks and rows are drawn from small sets, so hits, conflicts, activate push-outs and waits on a busy bank all occur often.

// File: rtl/dlat_pkg.sv
// Shared definitions for the DRAM bank latency calculator.
// Assumes: page policy arrives as a 2-bit code; code 3 behaves as close.
package dlat_pkg;

    typedef enum logic [1:0] {
        POL_OPEN      = 2'd0,
        POL_ADAPTIVE  = 2'd1,
        POL_CLOSE     = 2'd2,
        POL_CLOSE_ALT = 2'd3
    } page_pol_e;

    // True when the policy precharges after every access.
    function automatic logic pol_is_closing(input page_pol_e p);
        return p[1];
    endfunction

endpackage

// File: rtl/dlat_bank_table.sv
// Per-bank record store: open flag, open row, free cycle, earliest activate.
// One combinational read port and one write port; a write lands at the clock edge.
// Assumes NUM_BANKS is a power of two so every read index is in range.
module dlat_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int TIME_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_open,
    output logic [ROW_W-1:0]  rd_row,
    output logic [TIME_W-1:0] rd_free,
    output logic [TIME_W-1:0] rd_act,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic              wr_open,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [TIME_W-1:0] wr_free,
    input  logic [TIME_W-1:0] wr_act
);

    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_W-1:0]     row_arr  [NUM_BANKS];
    logic [TIME_W-1:0]    free_arr [NUM_BANKS];
    logic [TIME_W-1:0]    act_arr  [NUM_BANKS];

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic              open_q;
        logic [ROW_W-1:0]  row_q;
        logic [TIME_W-1:0] free_q;
        logic [TIME_W-1:0] act_q;
        logic              sel;

        assign sel = wr_en && (wr_bank == BANK_W'(gi));

        // Hold or update this bank's record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
                free_q <= '0;
                act_q  <= '0;
            end else if (sel) begin
                open_q <= wr_open;
                row_q  <= wr_row;
                free_q <= wr_free;
                act_q  <= wr_act;
            end
        end

        assign open_vec[gi] = open_q;
        assign row_arr[gi]  = row_q;
        assign free_arr[gi] = free_q;
        assign act_arr[gi]  = act_q;
    end

    // Read port selects the requested bank's record.
    always_comb begin
        rd_open = open_vec[rd_bank];
        rd_row  = row_arr[rd_bank];
        rd_free = free_arr[rd_bank];
        rd_act  = act_arr[rd_bank];
    end

    // R7: without a write, no bank's open flag moves.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(open_vec));

    // R7: a write to one bank touches at most that bank's open flag.
    assert_single_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $onehot0(open_vec ^ $past(open_vec)));

endmodule

// File: rtl/dlat_latency_calc.sv
// Combinational latency evaluation for one request against one bank record,
// plus the record that bank holds after the access.
// Assumes TIME_W > TP_W and that cycle sums never wrap within TIME_W bits.
module dlat_latency_calc
    import dlat_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int TIME_W = 32,
    parameter int TP_W   = 8,
    localparam int PAD_W = TIME_W - TP_W
) (
    input  page_pol_e         policy,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [TIME_W-1:0] req_now,
    input  logic              close_hint,
    input  logic [TP_W-1:0]   t_rp,
    input  logic [TP_W-1:0]   t_rcd,
    input  logic [TP_W-1:0]   t_cl,
    input  logic [TP_W-1:0]   t_rc,
    input  logic              cur_open,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [TIME_W-1:0] cur_free,
    input  logic [TIME_W-1:0] cur_act,
    output logic [TIME_W-1:0] acc_lat,
    output logic [TIME_W-1:0] bank_lat,
    output logic              hit,
    output logic              nxt_open,
    output logic [TIME_W-1:0] nxt_free,
    output logic [TIME_W-1:0] nxt_act
);

    logic [TIME_W-1:0] rp_w, rcd_w, cl_w, rc_w;
    logic [TIME_W-1:0] busy_wait, pre_dly, cand_act, act_push, miss_core, act_at;
    logic              closing, close_after;

    // Widen timing inputs to the cycle-count width.
    always_comb begin
        rp_w  = {{PAD_W{1'b0}}, t_rp};
        rcd_w = {{PAD_W{1'b0}}, t_rcd};
        cl_w  = {{PAD_W{1'b0}}, t_cl};
        rc_w  = {{PAD_W{1'b0}}, t_rc};
    end

    // Classify the access and form each latency term.
    always_comb begin
        closing   = pol_is_closing(policy);
        hit       = !closing && cur_open && (cur_row == req_row);
        busy_wait = (cur_free > req_now) ? (cur_free - req_now) : '0;
        pre_dly   = (!closing && cur_open) ? rp_w : '0;
        cand_act  = req_now + busy_wait + pre_dly;
        act_push  = (cand_act < cur_act) ? (cur_act - cand_act) : '0;
        miss_core = pre_dly + rcd_w + cl_w;
        act_at    = cand_act + act_push;
        if (hit) begin
            acc_lat  = busy_wait + cl_w;
            bank_lat = cl_w;
        end else begin
            acc_lat  = busy_wait + act_push + miss_core;
            bank_lat = miss_core;
        end
    end

    // Build the bank record left behind by this access.
    always_comb begin
        close_after = closing || ((policy == POL_ADAPTIVE) && close_hint);
        nxt_open    = !close_after;
        nxt_free    = req_now + acc_lat + (close_after ? rp_w : '0);
        nxt_act     = hit ? cur_act : (act_at + rc_w);
    end

endmodule

// File: rtl/dram_bank_latency.sv
// DRAM bank access latency calculator, top level.
// Reads the addressed bank's record, evaluates the latency, registers the
// result with a one-cycle valid pulse and writes back the updated record.
// Assumes configuration is stable while requests flow and req_now never decreases.
module dram_bank_latency
    import dlat_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int TIME_W    = 32,
    parameter int TP_W      = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_policy,
    input  logic [TP_W-1:0]   cfg_trp,
    input  logic [TP_W-1:0]   cfg_trcd,
    input  logic [TP_W-1:0]   cfg_tcl,
    input  logic [TP_W-1:0]   cfg_trc,
    input  logic              req_vld,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [TIME_W-1:0] req_now,
    input  logic              req_close_hint,
    output logic              res_vld,
    output logic [TIME_W-1:0] res_acc_lat,
    output logic [TIME_W-1:0] res_bank_lat,
    output logic              res_hit
);

    page_pol_e         policy;
    logic              cur_open, nxt_open, calc_hit;
    logic [ROW_W-1:0]  cur_row;
    logic [TIME_W-1:0] cur_free, cur_act, nxt_free, nxt_act;
    logic [TIME_W-1:0] calc_acc, calc_bank;

    assign policy = page_pol_e'(cfg_policy);

    dlat_bank_table #(
        .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TIME_W(TIME_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .rd_bank(req_bank), .rd_open(cur_open), .rd_row(cur_row),
        .rd_free(cur_free), .rd_act(cur_act),
        .wr_en(req_vld), .wr_bank(req_bank), .wr_open(nxt_open),
        .wr_row(req_row), .wr_free(nxt_free), .wr_act(nxt_act)
    );

    dlat_latency_calc #(
        .ROW_W(ROW_W), .TIME_W(TIME_W), .TP_W(TP_W)
    ) calc_i (
        .policy(policy), .req_row(req_row), .req_now(req_now),
        .close_hint(req_close_hint),
        .t_rp(cfg_trp), .t_rcd(cfg_trcd), .t_cl(cfg_tcl), .t_rc(cfg_trc),
        .cur_open(cur_open), .cur_row(cur_row), .cur_free(cur_free), .cur_act(cur_act),
        .acc_lat(calc_acc), .bank_lat(calc_bank), .hit(calc_hit),
        .nxt_open(nxt_open), .nxt_free(nxt_free), .nxt_act(nxt_act)
    );

    // Register the result and raise the valid pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld      <= 1'b0;
            res_acc_lat  <= '0;
            res_bank_lat <= '0;
            res_hit      <= 1'b0;
        end else begin
            res_vld <= req_vld;
            if (req_vld) begin
                res_acc_lat  <= calc_acc;
                res_bank_lat <= calc_bank;
                res_hit      <= calc_hit;
            end
        end
    end

    // R1: each request produces a result the next cycle.
    assert_req_to_res_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);

    // R1: no result without a request.
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld);

    // R2: a busy bank's remaining time is never dropped from the latency.
    assert_busy_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (cur_free > req_now)) |=>
            (res_acc_lat >= $past(cur_free - req_now)));

    // R3: a hit costs exactly one column access of bank time.
    assert_hit_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit) |-> (res_bank_lat == TIME_W'(cfg_tcl)));

    // R6: a miss always pays at least activate plus column time.
    assert_miss_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |->
            (res_acc_lat >= TIME_W'(cfg_trcd) + TIME_W'(cfg_tcl)));

    // R6: bank-busy time is part of the total latency.
    assert_bank_within_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_bank_lat <= res_acc_lat));

    // R9: the close policy never reports a hit.
    assert_close_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_policy[1]) |=> !res_hit);

endmodule

// File: tb/dram_bank_latency_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// each result compared with a bench model built from the requirements.
module dram_bank_latency_tb_top;

    localparam int NB = 8;
    localparam int RW = 14;
    localparam int TW = 32;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_policy = 2'd0;
    logic [PW-1:0] cfg_trp = 8'd5, cfg_trcd = 8'd6, cfg_tcl = 8'd4, cfg_trc = 8'd20;
    logic          req_vld = 1'b0;
    logic [2:0]    req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [TW-1:0] req_now = '0;
    logic          req_close_hint = 1'b0;
    logic          res_vld, res_hit;
    logic [TW-1:0] res_acc_lat, res_bank_lat;

    always #2 clk = ~clk;

    dram_bank_latency dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_tcl(cfg_tcl), .cfg_trc(cfg_trc),
        .req_vld(req_vld), .req_bank(req_bank), .req_row(req_row),
        .req_now(req_now), .req_close_hint(req_close_hint),
        .res_vld(res_vld), .res_acc_lat(res_acc_lat),
        .res_bank_lat(res_bank_lat), .res_hit(res_hit)
    );

    int nchk = 0;
    int nfail = 0;

    // Bench model of each bank's record.
    bit          m_open [NB];
    int unsigned m_row  [NB];
    int unsigned m_free [NB];
    int unsigned m_act  [NB];

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 1'b0; m_row[i] = 0; m_free[i] = 0; m_act[i] = 0;
        end
    endfunction

    // Expected latency per R2..R10, updating the model record.
    function automatic void model_step(input int b, input int unsigned row,
        input int unsigned now, input bit hint, input int pol,
        output int unsigned e_acc, output int unsigned e_bank, output bit e_hit,
        output string tag);
        bit closing, close_after;
        int unsigned wt, pre, cand, push;
        closing = (pol >= 2);
        e_hit = !closing && m_open[b] && (m_row[b] == row);
        wt = (m_free[b] > now) ? m_free[b] - now : 0;
        pre = (!closing && m_open[b]) ? cfg_trp : 0;
        cand = now + wt + pre;
        push = (cand < m_act[b]) ? m_act[b] - cand : 0;
        if (e_hit) begin
            e_acc = wt + cfg_tcl; e_bank = cfg_tcl;
        end else begin
            e_bank = pre + cfg_trcd + cfg_tcl; e_acc = wt + push + e_bank;
        end
        tag = closing ? "R9" : e_hit ? "R3" : (push > 0) ? "R5" :
              (pre > 0) ? "R4" : (wt > 0) ? "R2" : "R6";
        close_after = closing || (pol == 1 && hint);
        if (!e_hit) m_act[b] = cand + push + cfg_trc;
        m_open[b] = !close_after;
        m_row[b] = row;
        m_free[b] = now + e_acc + (close_after ? int'(cfg_trp) : 0);
    endfunction

    // Issue one request, then compare the registered result.
    task automatic do_req(input int b, input int unsigned row, input int unsigned now,
                          input bit hint, input string force_tag);
        int unsigned e_acc, e_bank;
        bit e_hit;
        string tag;
        @(negedge clk);
        req_vld = 1'b1; req_bank = 3'(b); req_row = RW'(row);
        req_now = now; req_close_hint = hint;
        model_step(b, row, now, hint, int'(cfg_policy), e_acc, e_bank, e_hit, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_vld = 1'b0;
        chk("R1", "valid", res_vld, 1);
        chk(tag, "acc_lat", res_acc_lat, e_acc);
        chk(tag, "bank_lat", res_bank_lat, e_bank);
        chk(tag, "hit", res_hit, e_hit);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned now;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11", "valid after reset", res_vld, 0);

        // R11 + R6: first access to a closed bank: 6+4 = 10, no precharge.
        cfg_policy = 2'd0;
        do_req(0, 10, 100, 0, "R11");
        chk("R6", "literal miss from closed", res_acc_lat, 10);
        // R2 + R3: same row while busy until 110: wait 5 + tCL 4.
        do_req(0, 10, 105, 0, "R2");
        chk("R3", "literal hit", res_acc_lat, 9);
        // R4 + R5 + R7: conflict: wait 8, tRP 5, activate pushed by 1 to 120.
        do_req(0, 11, 106, 0, "R5");
        chk("R4", "literal conflict", res_acc_lat, 24);
        chk("R7", "literal conflict bank", res_bank_lat, 15);
        // R1: idle cycle gives no result.
        @(negedge clk);
        chk("R1", "valid when idle", res_vld, 0);

        // R10: open policy ignores the close hint; next access hits.
        do_req(1, 3, 200, 1, "R10");
        do_req(1, 3, 250, 1, "R10");
        chk("R10", "hit despite hint", res_hit, 1);

        // R8: adaptive with hint closes the row; reopen pays no precharge.
        cfg_policy = 2'd1;
        do_req(2, 4, 300, 1, "R8");
        do_req(2, 4, 301, 0, "R8");
        chk("R8", "no hit after adaptive close", res_hit, 0);
        // R8: adaptive without hint keeps the row open.
        do_req(2, 4, 400, 0, "R8");
        chk("R8", "hit without hint", res_hit, 1);

        // R9: close policy, both codes, repeated row never hits.
        cfg_policy = 2'd2;
        do_req(3, 7, 500, 0, "R9");
        do_req(3, 7, 501, 0, "R9");
        cfg_policy = 2'd3;
        do_req(3, 7, 502, 1, "R9");
        chk("R9", "close code 3 no hit", res_hit, 0);

        // Random phases per policy, fixed seed.
        void'($urandom(32'h5eed_1234));
        now = 600;
        for (int ph = 0; ph < 4; ph++) begin
            @(negedge clk);
            cfg_policy = 2'(ph);
            cfg_trp  = 8'(2 + $urandom_range(0, 10));
            cfg_trcd = 8'(2 + $urandom_range(0, 10));
            cfg_tcl  = 8'(1 + $urandom_range(0, 8));
            cfg_trc  = 8'(10 + $urandom_range(0, 30));
            for (int k = 0; k < 150; k++) begin
                now = now + $urandom_range(0, 12);
                do_req($urandom_range(0, 3), $urandom_range(0, 2), now,
                       1'($urandom_range(0, 1)), "");
                if ($urandom_range(0, 9) == 0) begin
                    @(negedge clk);
                    chk("R1", "valid when idle", res_vld, 0);
                end
            end
        end

        // R11: reset again restores closed, idle banks.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R11", "valid after second reset", res_vld, 0);
        cfg_policy = 2'd0;
        do_req(0, 11, 50, 0, "R11");

        finish_run();
    end

endmodule